// File: doc/BRIEF.md
# Three-Port Lane Crossbar Controller

This block is the digital control and data path of a three-port, multi-lane crossbar. Port C is the common port and ports A and B are its two alternates. Each lane carries one data bit per port in each direction: a receive bit in and a transmit bit out. Every lane is steered on its own. Lanes are routed between C and either alternate, mirrored from C to both alternates for diagnostics, or looped back on any single port. The output is then shaped by per-lane polarity inversion, lane enables, per-output disable masks and a global power-down.

Each transmit lane reports one of three states. An active lane carries data. A squelched lane is still enabled but holds a constant 0. A disabled lane raises its output-enable-low flag. When the routing leaves an output with no source, the port's fast-switch setting picks between squelch and disable.

Configuration comes from one of two sets of inputs, selected by `cfg_src_gpio`. One set is the pin-level set and the other is the register-bank set. Polarity, output-disable masks and input power-down exist only in the register set. All outputs are registered, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `lsw_lane_switch`

## Requirements
- R1: While `rst_n` is low, every transmit lane is disabled: `tx_oe_n_*` = 1, `tx_sq_*` = 0, `tx_*` = 0.
- R2: In normal mode the C output of lane l carries A's receive bit when select bit l is 0, and B's when it is 1. The alternate named by the select bit carries C's receive bit.
- R3: An output that no path feeds is squelched (`tx_oe_n`=0, `tx_sq`=1, data 0) when its port's fast-switch bit is 1, and disabled (`tx_oe_n`=1, `tx_sq`=0, data 0) when it is 0. No lane ever shows both flags, and a flagged lane always drives 0.
- R4: With diagnostic mode on, A and B both carry C's receive bit on every lane, while C's output still follows the lane select bit.
- R5: A port with its loopback bit set (bit 0 = A, bit 1 = B, bit 2 = C) transmits its own receive bits. This takes precedence over diagnostic and normal routing.
- R6: A polarity bit of 1 (`reg_pol[p*LANES+l]`, with p = 0 for A, 1 for B, 2 for C) inverts that active output. An idle output stays 0.
- R7: A lane-enable bit of 0 disables that lane on all three ports, whatever the loopback or routing.
- R8: An output-disable bit of 1 (`reg_out_dis[p*LANES+l]`, same layout as R6) disables that single output lane, even when it is looped back.
- R9: When a port's input power-down bit is set (`reg_in_off`, bit order as in R5), its receive data counts as absent. Every output fed from it becomes idle, as in R3.
- R10: Global power-down disables every output lane of every port.
- R11: With `cfg_src_gpio` = 1 the pin set is used. The single `pin_fast_sw` applies to all ports, and the polarity, output-disable and input power-down settings are ignored. With `cfg_src_gpio` = 0 the register set is used.
- R12: Each output changes exactly one clock after its inputs change, so a new input pattern can be applied on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_a | input | LANES | Receive bits of port A |
| rx_b | input | LANES | Receive bits of port B |
| rx_c | input | LANES | Receive bits of port C |
| cfg_src_gpio | input | 1 | 1 selects the pin configuration set, 0 the register set |
| pin_pwrdn | input | 1 | Pin set: global power-down |
| pin_diag | input | 1 | Pin set: diagnostic mirror mode |
| pin_loop | input | 3 | Pin set: per-port loopback (A, B, C in bits 0..2) |
| pin_sel | input | LANES | Pin set: per-lane alternate select (0 = A, 1 = B) |
| pin_lane_en | input | LANES | Pin set: per-lane enable |
| pin_fast_sw | input | 1 | Pin set: idle outputs squelched (1) or disabled (0), all ports |
| reg_pwrdn | input | 1 | Register set: global power-down |
| reg_diag | input | 1 | Register set: diagnostic mirror mode |
| reg_loop | input | 3 | Register set: per-port loopback |
| reg_sel | input | LANES | Register set: per-lane alternate select |
| reg_lane_en | input | LANES | Register set: per-lane enable |
| reg_fast_sw | input | 3 | Register set: per-port idle handling |
| reg_in_off | input | 3 | Register set: per-port input power-down |
| reg_pol | input | 3*LANES | Register set: per-output polarity inversion |
| reg_out_dis | input | 3*LANES | Register set: per-output disable mask |
| tx_a | output | LANES | Transmit bits of port A |
| tx_b | output | LANES | Transmit bits of port B |
| tx_c | output | LANES | Transmit bits of port C |
| tx_oe_n_a | output | LANES | Port A lane disabled flags |
| tx_oe_n_b | output | LANES | Port B lane disabled flags |
| tx_oe_n_c | output | LANES | Port C lane disabled flags |
| tx_sq_a | output | LANES | Port A lane squelched flags |
| tx_sq_b | output | LANES | Port B lane squelched flags |
| tx_sq_c | output | LANES | Port C lane squelched flags |

## Verification
Loopback on one port can coincide in the same cycle with a disabling control: a cleared lane enable, an output-disable bit, or the diagnostic mirror feeding the other alternate. The bench sets these together in a single configuration. One example is A looped back with diagnostic on, lane enable 0110 and one A output masked. The expected value for each lane comes from the stated priority order, which the bench evaluates independently. A priority inversion shows up as a lane reported active or squelched where it should be disabled, or as a lane carrying C data where it should carry its own looped data.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [1:0] {
    P_A = 2'd0,
    P_B = 2'd1,
    P_C = 2'd2
  } port_e;

  typedef enum logic [2:0] {
    FD_NONE = 3'd0,
    FD_A    = 3'd1,
    FD_B    = 3'd2,
    FD_C    = 3'd3
  } feed_e;

  typedef enum logic [1:0] {
    LS_OFF = 2'd0,
    LS_SQ  = 2'd1,
    LS_ACT = 2'd2
  } lane_st_e;

  // Which receive port feeds a given output, for one lane.
  function automatic feed_e pick_feed(port_e port, logic loop_self,
                                      logic diag, logic sel_bit);
    feed_e f;
    if (loop_self) begin
      f = (port == P_A) ? FD_A : ((port == P_B) ? FD_B : FD_C);
    end else if (port == P_C) begin
      f = sel_bit ? FD_B : FD_A;
    end else if (diag) begin
      f = FD_C;
    end else if ((port == P_B) == sel_bit) begin
      f = FD_C;
    end else begin
      f = FD_NONE;
    end
    return f;
  endfunction

  // Returns {valid, data} for the chosen feed.
  function automatic logic [1:0] feed_take(feed_e f, logic a, logic b,
                                           logic c, logic [2:0] in_off);
    logic [1:0] r;
    unique case (f)
      FD_A:    r = {~in_off[0], a & ~in_off[0]};
      FD_B:    r = {~in_off[1], b & ~in_off[1]};
      FD_C:    r = {~in_off[2], c & ~in_off[2]};
      default: r = 2'b00;
    endcase
    return r;
  endfunction

  function automatic lane_st_e idle_state(logic fast);
    return fast ? LS_SQ : LS_OFF;
  endfunction

  // Priority: power-down, lane disable, output disable, then routing.
  function automatic lane_st_e resolve(logic pd, logic lane_en, logic odis,
                                       logic src_ok, logic fast);
    lane_st_e s;
    if (pd || !lane_en || odis) s = LS_OFF;
    else if (src_ok)            s = LS_ACT;
    else                        s = idle_state(fast);
    return s;
  endfunction

endpackage

// File: rtl/lsw_cfg_mux.sv
module lsw_cfg_mux #(
  parameter int LANES = 4
) (
  input  logic                 cfg_src_gpio,
  input  logic                 pin_pwrdn,
  input  logic                 pin_diag,
  input  logic [2:0]           pin_loop,
  input  logic [LANES-1:0]     pin_sel,
  input  logic [LANES-1:0]     pin_lane_en,
  input  logic                 pin_fast_sw,
  input  logic                 reg_pwrdn,
  input  logic                 reg_diag,
  input  logic [2:0]           reg_loop,
  input  logic [LANES-1:0]     reg_sel,
  input  logic [LANES-1:0]     reg_lane_en,
  input  logic [2:0]           reg_fast_sw,
  input  logic [2:0]           reg_in_off,
  input  logic [3*LANES-1:0]   reg_pol,
  input  logic [3*LANES-1:0]   reg_out_dis,
  output logic                 eff_pwrdn,
  output logic                 eff_diag,
  output logic [2:0]           eff_loop,
  output logic [LANES-1:0]     eff_sel,
  output logic [LANES-1:0]     eff_lane_en,
  output logic [2:0]           eff_fast,
  output logic [2:0]           eff_in_off,
  output logic [3*LANES-1:0]   eff_pol,
  output logic [3*LANES-1:0]   eff_odis
);
  localparam int NOUT = 3 * LANES;

  always_comb begin
    if (cfg_src_gpio) begin
      eff_pwrdn   = pin_pwrdn;
      eff_diag    = pin_diag;
      eff_loop    = pin_loop;
      eff_sel     = pin_sel;
      eff_lane_en = pin_lane_en;
      eff_fast    = {3{pin_fast_sw}};
      eff_in_off  = 3'b000;
      eff_pol     = {NOUT{1'b0}};
      eff_odis    = {NOUT{1'b0}};
    end else begin
      eff_pwrdn   = reg_pwrdn;
      eff_diag    = reg_diag;
      eff_loop    = reg_loop;
      eff_sel     = reg_sel;
      eff_lane_en = reg_lane_en;
      eff_fast    = reg_fast_sw;
      eff_in_off  = reg_in_off;
      eff_pol     = reg_pol;
      eff_odis    = reg_out_dis;
    end
  end
endmodule

// File: rtl/lsw_router.sv
module lsw_router
  import lsw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]   rx_a,
  input  logic [LANES-1:0]   rx_b,
  input  logic [LANES-1:0]   rx_c,
  input  logic [LANES-1:0]   sel,
  input  logic [2:0]         loopb,
  input  logic               diag,
  input  logic [2:0]         in_off,
  output logic [3*LANES-1:0] src_data,
  output logic [3*LANES-1:0] src_ok
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar p = 0; p < 3; p++) begin : g_port
      feed_e      feed;
      logic [1:0] okd;
      assign feed = pick_feed(port_e'(p), loopb[p], diag, sel[l]);
      assign okd  = feed_take(feed, rx_a[l], rx_b[l], rx_c[l], in_off);
      assign src_ok[p*LANES+l]   = okd[1];
      assign src_data[p*LANES+l] = okd[0];
    end
  end
endmodule

// File: rtl/lsw_out_stage.sv
module lsw_out_stage
  import lsw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrdn,
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] odis,
  input  logic             fast,
  input  logic [LANES-1:0] pol,
  input  logic [LANES-1:0] src_data,
  input  logic [LANES-1:0] src_ok,
  output logic [LANES-1:0] tx,
  output logic [LANES-1:0] oe_n,
  output logic [LANES-1:0] sq
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_st_e st;
    logic     tx_q, oe_n_q, sq_q;
    assign st = resolve(pwrdn, lane_en[l], odis[l], src_ok[l], fast);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_q   <= 1'b0;
        oe_n_q <= 1'b1;
        sq_q   <= 1'b0;
      end else begin
        tx_q   <= (st == LS_ACT) & (src_data[l] ^ pol[l]);
        oe_n_q <= (st == LS_OFF);
        sq_q   <= (st == LS_SQ);
      end
    end

    assign tx[l]   = tx_q;
    assign oe_n[l] = oe_n_q;
    assign sq[l]   = sq_q;
  end
endmodule

// File: rtl/lsw_lane_switch.sv
module lsw_lane_switch
  import lsw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES-1:0]     rx_a,
  input  logic [LANES-1:0]     rx_b,
  input  logic [LANES-1:0]     rx_c,
  input  logic                 cfg_src_gpio,
  input  logic                 pin_pwrdn,
  input  logic                 pin_diag,
  input  logic [2:0]           pin_loop,
  input  logic [LANES-1:0]     pin_sel,
  input  logic [LANES-1:0]     pin_lane_en,
  input  logic                 pin_fast_sw,
  input  logic                 reg_pwrdn,
  input  logic                 reg_diag,
  input  logic [2:0]           reg_loop,
  input  logic [LANES-1:0]     reg_sel,
  input  logic [LANES-1:0]     reg_lane_en,
  input  logic [2:0]           reg_fast_sw,
  input  logic [2:0]           reg_in_off,
  input  logic [3*LANES-1:0]   reg_pol,
  input  logic [3*LANES-1:0]   reg_out_dis,
  output logic [LANES-1:0]     tx_a,
  output logic [LANES-1:0]     tx_b,
  output logic [LANES-1:0]     tx_c,
  output logic [LANES-1:0]     tx_oe_n_a,
  output logic [LANES-1:0]     tx_oe_n_b,
  output logic [LANES-1:0]     tx_oe_n_c,
  output logic [LANES-1:0]     tx_sq_a,
  output logic [LANES-1:0]     tx_sq_b,
  output logic [LANES-1:0]     tx_sq_c
);
  localparam int NOUT = 3 * LANES;

  // Named internal events, visible to the bound checker.
  logic             cfg_pwrdn_w;
  logic             cfg_diag_w;
  logic [2:0]       cfg_loop_w;
  logic [LANES-1:0] cfg_sel_w;
  logic [LANES-1:0] cfg_lane_en_w;
  logic [2:0]       cfg_fast_w;
  logic [2:0]       cfg_in_off_w;
  logic [NOUT-1:0]  cfg_pol_w;
  logic [NOUT-1:0]  cfg_odis_w;
  logic [NOUT-1:0]  src_data_w;
  logic [NOUT-1:0]  src_ok_w;
  logic [NOUT-1:0]  tx_all_w;
  logic [NOUT-1:0]  oe_n_all_w;
  logic [NOUT-1:0]  sq_all_w;

  lsw_cfg_mux #(.LANES(LANES)) u_cfg (
    .cfg_src_gpio (cfg_src_gpio),
    .pin_pwrdn    (pin_pwrdn),
    .pin_diag     (pin_diag),
    .pin_loop     (pin_loop),
    .pin_sel      (pin_sel),
    .pin_lane_en  (pin_lane_en),
    .pin_fast_sw  (pin_fast_sw),
    .reg_pwrdn    (reg_pwrdn),
    .reg_diag     (reg_diag),
    .reg_loop     (reg_loop),
    .reg_sel      (reg_sel),
    .reg_lane_en  (reg_lane_en),
    .reg_fast_sw  (reg_fast_sw),
    .reg_in_off   (reg_in_off),
    .reg_pol      (reg_pol),
    .reg_out_dis  (reg_out_dis),
    .eff_pwrdn    (cfg_pwrdn_w),
    .eff_diag     (cfg_diag_w),
    .eff_loop     (cfg_loop_w),
    .eff_sel      (cfg_sel_w),
    .eff_lane_en  (cfg_lane_en_w),
    .eff_fast     (cfg_fast_w),
    .eff_in_off   (cfg_in_off_w),
    .eff_pol      (cfg_pol_w),
    .eff_odis     (cfg_odis_w)
  );

  lsw_router #(.LANES(LANES)) u_route (
    .rx_a     (rx_a),
    .rx_b     (rx_b),
    .rx_c     (rx_c),
    .sel      (cfg_sel_w),
    .loopb    (cfg_loop_w),
    .diag     (cfg_diag_w),
    .in_off   (cfg_in_off_w),
    .src_data (src_data_w),
    .src_ok   (src_ok_w)
  );

  for (genvar p = 0; p < 3; p++) begin : g_port
    lsw_out_stage #(.LANES(LANES)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwrdn    (cfg_pwrdn_w),
      .lane_en  (cfg_lane_en_w),
      .odis     (cfg_odis_w[p*LANES +: LANES]),
      .fast     (cfg_fast_w[p]),
      .pol      (cfg_pol_w[p*LANES +: LANES]),
      .src_data (src_data_w[p*LANES +: LANES]),
      .src_ok   (src_ok_w[p*LANES +: LANES]),
      .tx       (tx_all_w[p*LANES +: LANES]),
      .oe_n     (oe_n_all_w[p*LANES +: LANES]),
      .sq       (sq_all_w[p*LANES +: LANES])
    );
  end

  assign tx_a      = tx_all_w[0*LANES +: LANES];
  assign tx_b      = tx_all_w[1*LANES +: LANES];
  assign tx_c      = tx_all_w[2*LANES +: LANES];
  assign tx_oe_n_a = oe_n_all_w[0*LANES +: LANES];
  assign tx_oe_n_b = oe_n_all_w[1*LANES +: LANES];
  assign tx_oe_n_c = oe_n_all_w[2*LANES +: LANES];
  assign tx_sq_a   = sq_all_w[0*LANES +: LANES];
  assign tx_sq_b   = sq_all_w[1*LANES +: LANES];
  assign tx_sq_c   = sq_all_w[2*LANES +: LANES];
endmodule

// File: rtl/lsw_lane_switch_chk.sv
module lsw_lane_switch_chk #(
  parameter int LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pwrdn,
  input logic [LANES-1:0]     lane_en,
  input logic [3*LANES-1:0]   odis,
  input logic [3*LANES-1:0]   tx_all,
  input logic [3*LANES-1:0]   oe_n_all,
  input logic [3*LANES-1:0]   sq_all
);
  localparam int NOUT = 3 * LANES;

  logic [NOUT-1:0] lane_off_rep;
  assign lane_off_rep = ~{3{lane_en}};

  // R10: global power-down turns every output off one clock later
  assert_pd_all_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> (oe_n_all == {NOUT{1'b1}}) && (sq_all == '0) && (tx_all == '0));

  // R3: a lane is never both squelched and disabled
  assert_state_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n_all & sq_all) == '0);

  // R3: a squelched or disabled lane drives 0
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_all & (oe_n_all | sq_all)) == '0);

  // R7: a cleared lane enable disables that lane on every port
  assert_lane_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lane_off_rep) & ~oe_n_all) == '0));

  // R8: a set output-disable bit disables that output
  assert_out_dis_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(odis) & ~oe_n_all) == '0));
endmodule

bind lsw_lane_switch lsw_lane_switch_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwrdn    (cfg_pwrdn_w),
  .lane_en  (cfg_lane_en_w),
  .odis     (cfg_odis_w),
  .tx_all   (tx_all_w),
  .oe_n_all (oe_n_all_w),
  .sq_all   (sq_all_w)
);

// File: tb/lsw_lane_switch_test.sv
`timescale 1ns/1ps
module lsw_lane_switch_test;
  localparam int L = 4;
  localparam int N = 3 * L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [L-1:0] rx_a, rx_b, rx_c;
  logic         cfg_src_gpio, pin_pwrdn, pin_diag, pin_fast_sw;
  logic [2:0]   pin_loop;
  logic [L-1:0] pin_sel, pin_lane_en;
  logic         reg_pwrdn, reg_diag;
  logic [2:0]   reg_loop, reg_fast_sw, reg_in_off;
  logic [L-1:0] reg_sel, reg_lane_en;
  logic [N-1:0] reg_pol, reg_out_dis;
  logic [L-1:0] tx_a, tx_b, tx_c, oen_a, oen_b, oen_c, sq_a, sq_b, sq_c;

  lsw_lane_switch #(.LANES(L)) uut (
    .clk(clk), .rst_n(rst_n), .rx_a(rx_a), .rx_b(rx_b), .rx_c(rx_c),
    .cfg_src_gpio(cfg_src_gpio), .pin_pwrdn(pin_pwrdn), .pin_diag(pin_diag),
    .pin_loop(pin_loop), .pin_sel(pin_sel), .pin_lane_en(pin_lane_en),
    .pin_fast_sw(pin_fast_sw), .reg_pwrdn(reg_pwrdn), .reg_diag(reg_diag),
    .reg_loop(reg_loop), .reg_sel(reg_sel), .reg_lane_en(reg_lane_en),
    .reg_fast_sw(reg_fast_sw), .reg_in_off(reg_in_off), .reg_pol(reg_pol),
    .reg_out_dis(reg_out_dis), .tx_a(tx_a), .tx_b(tx_b), .tx_c(tx_c),
    .tx_oe_n_a(oen_a), .tx_oe_n_b(oen_b), .tx_oe_n_c(oen_c),
    .tx_sq_a(sq_a), .tx_sq_b(sq_b), .tx_sq_c(sq_c)
  );

  typedef struct {
    logic [N-1:0] tx;
    logic [N-1:0] oen;
    logic [N-1:0] sq;
    int           due;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected outputs from the requirements (priority order written out).
  task automatic predict(output exp_t e);
    logic       gp, pd, dg, fs;
    logic [2:0] lp, inoff;
    logic [L-1:0] s, le;
    logic [N-1:0] pl, od;
    logic [L-1:0] rxs [3];
    gp = cfg_src_gpio;
    pd = gp ? pin_pwrdn : reg_pwrdn;
    dg = gp ? pin_diag : reg_diag;
    lp = gp ? pin_loop : reg_loop;
    s  = gp ? pin_sel : reg_sel;
    le = gp ? pin_lane_en : reg_lane_en;
    inoff = gp ? 3'b000 : reg_in_off;
    pl = gp ? '0 : reg_pol;
    od = gp ? '0 : reg_out_dis;
    rxs[0] = rx_a; rxs[1] = rx_b; rxs[2] = rx_c;
    for (int p = 0; p < 3; p++) begin
      fs = gp ? pin_fast_sw : reg_fast_sw[p];
      for (int l = 0; l < L; l++) begin
        int k;
        int src;
        k = p * L + l;
        if (lp[p])             src = p;
        else if (p == 2)       src = s[l] ? 1 : 0;
        else if (dg)           src = 2;
        else if (s[l] == (p == 1)) src = 2;
        else                   src = -1;
        if (src >= 0 && inoff[src]) src = -1;
        if (pd || !le[l] || od[k]) begin
          e.tx[k] = 1'b0; e.oen[k] = 1'b1; e.sq[k] = 1'b0;
        end else if (src >= 0) begin
          e.tx[k] = rxs[src][l] ^ pl[k]; e.oen[k] = 1'b0; e.sq[k] = 1'b0;
        end else begin
          e.tx[k] = 1'b0; e.oen[k] = ~fs; e.sq[k] = fs;
        end
      end
    end
  endtask

  // Driver: called just after a falling edge; result due after next rise.
  task automatic apply(string tag, logic [L-1:0] a, logic [L-1:0] b,
                       logic [L-1:0] c);
    exp_t e;
    rx_a = a; rx_b = b; rx_c = c;
    predict(e);
    e.due = cyc + 1;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if ({tx_c, tx_b, tx_a} !== e.tx || {oen_c, oen_b, oen_a} !== e.oen ||
          {sq_c, sq_b, sq_a} !== e.sq) begin
        n_fail++;
        $display("FAIL %s: tx=%h oe_n=%h sq=%h expected tx=%h oe_n=%h sq=%h",
                 e.tag, {tx_c, tx_b, tx_a}, {oen_c, oen_b, oen_a},
                 {sq_c, sq_b, sq_a}, e.tx, e.oen, e.sq);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  task automatic reg_defaults();
    cfg_src_gpio = 0; reg_pwrdn = 0; reg_diag = 0; reg_loop = 3'b000;
    reg_sel = '0; reg_lane_en = '1; reg_fast_sw = 3'b000; reg_in_off = 3'b000;
    reg_pol = '0; reg_out_dis = '0;
  endtask

  initial begin
    rx_a = '0; rx_b = '0; rx_c = '0;
    pin_pwrdn = 0; pin_diag = 0; pin_loop = '0; pin_sel = '0;
    pin_lane_en = '1; pin_fast_sw = 0;
    reg_defaults();
    repeat (3) @(negedge clk);
    // R1: reset state
    n_tests++;
    if ({tx_c, tx_b, tx_a} !== '0 || {oen_c, oen_b, oen_a} !== '1 ||
        {sq_c, sq_b, sq_a} !== '0) begin
      n_fail++;
      $display("FAIL R1: tx=%h oe_n=%h sq=%h expected tx=0 oe_n=fff sq=0",
               {tx_c, tx_b, tx_a}, {oen_c, oen_b, oen_a}, {sq_c, sq_b, sq_a});
    end
    rst_n = 1;
    @(negedge clk);

    // R2 + R3: normal routing, idle outputs disabled
    reg_sel = 4'b0101;
    apply("R2 normal sel=0101", 4'b1010, 4'b0110, 4'b1101);
    apply("R2 normal sel=0101 b", 4'b0101, 4'b1001, 4'b0011);
    reg_sel = 4'b1010;
    apply("R2 normal sel=1010", 4'b1111, 4'b0000, 4'b1001);
    // R3: idle outputs squelched on two ports, disabled on the third
    reg_fast_sw = 3'b011;
    apply("R3 fast mixed", 4'b0110, 4'b1011, 4'b1110);
    reg_fast_sw = 3'b111;
    apply("R3 fast all", 4'b1001, 4'b0110, 4'b0101);
    // R12: back-to-back patterns, each one cycle later
    for (int i = 0; i < 6; i++)
      apply("R12 back-to-back", 4'(i * 3), 4'(i * 5 + 1), 4'(15 - i));
    // R4: diagnostic mirror
    reg_diag = 1; reg_sel = 4'b0011;
    apply("R4 diag", 4'b1100, 4'b0011, 4'b1011);
    apply("R4 diag b", 4'b0101, 4'b1010, 4'b0110);
    // R5: loopback on A with diag, then on C, then all
    reg_loop = 3'b001;
    apply("R5 loop A over diag", 4'b1001, 4'b0110, 4'b1111);
    reg_diag = 0; reg_loop = 3'b100;
    apply("R5 loop C", 4'b0011, 4'b1100, 4'b1010);
    reg_loop = 3'b111;
    apply("R5 loop all", 4'b0110, 4'b1001, 4'b0101);
    // R6: polarity on active outputs; idle ones stay 0
    reg_loop = 3'b000; reg_sel = 4'b0000; reg_fast_sw = 3'b111;
    reg_pol = 12'hF5A;
    apply("R6 polarity", 4'b1100, 4'b1010, 4'b0110);
    reg_pol = '0;
    // R7: lane disable beats loopback and diag
    reg_loop = 3'b001; reg_diag = 1; reg_lane_en = 4'b0110;
    apply("R7 lane disable", 4'b1111, 4'b1111, 4'b1111);
    // R8: output disable together with loopback
    reg_out_dis = 12'h204;
    apply("R8 out disable", 4'b1011, 4'b0111, 4'b1110);
    reg_lane_en = '1; reg_out_dis = 12'h0F1; reg_loop = 3'b010;
    apply("R8 out disable b", 4'b0101, 4'b1110, 4'b0011);
    reg_out_dis = '0; reg_loop = 3'b000; reg_diag = 0;
    // R9: input power-down of C and of A
    reg_in_off = 3'b100; reg_sel = 4'b0110; reg_fast_sw = 3'b010;
    apply("R9 in_off C", 4'b1111, 4'b1111, 4'b1111);
    reg_in_off = 3'b001; reg_loop = 3'b001;
    apply("R9 in_off A", 4'b1111, 4'b0101, 4'b1010);
    reg_in_off = 3'b000; reg_loop = 3'b000;
    // R10: global power-down
    reg_pwrdn = 1; reg_loop = 3'b111;
    apply("R10 pwrdn", 4'b1111, 4'b1111, 4'b1111);
    reg_pwrdn = 0; reg_loop = 3'b000;
    // R11: pin set selected; register-only settings ignored
    reg_pol = '1; reg_out_dis = 12'h00F; reg_in_off = 3'b111;
    cfg_src_gpio = 1; pin_sel = 4'b1001; pin_fast_sw = 1;
    apply("R11 gpio ignores reg-only", 4'b1010, 4'b0101, 4'b1100);
    pin_diag = 1; pin_loop = 3'b010; pin_lane_en = 4'b1011;
    apply("R11 gpio diag/loop", 4'b0011, 4'b0110, 4'b1001);
    pin_pwrdn = 1;
    apply("R11 gpio pwrdn", 4'b1111, 4'b1111, 4'b1111);
    pin_pwrdn = 0; pin_diag = 0; pin_loop = 3'b000; pin_fast_sw = 0;
    apply("R11 gpio fast=0", 4'b0110, 4'b1001, 4'b0011);
    cfg_src_gpio = 0;
    apply("R11 back to regs", 4'b0110, 4'b1001, 4'b0011);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule